// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block sequences descriptor fetches for one DMA channel that runs from a chain of configuration records held in memory. Software first places the address of the first record in a pointer input. It then sets the channel-enable and chain-mode bits of the channel configuration word. The loader reads the record one word at a time over a simple read port, with at most one read in flight. Each word lands in the channel's working registers. The loader then pulses a start strobe to the transfer engine and waits for its done pulse.

When a record's transfer completes, the loader reports it. If the record is not flagged as the final one, the loader follows its next pointer and fetches the next record with no software action. A pointer always addresses the source-address word of its target record, which is where the register image starts. Any header words that sit before that field in memory are never read. The chain is a ring: the final record points back to the first. The loader therefore stops on the final-record flag carried in the fragment-length word, and never on the pointer value.

A single transfer that is not chained is programmed directly by other logic. For that case the loader stays inactive, either because chain mode is off or because the pointer is zero. A read that returns an error response stops the chain and raises a sticky error flag.

Top module: `ll_desc_loader`

## Requirements
- R1: While reset is held, and directly after it, mem_req, xfer_start, rec_done, chain_done and cfg_err are all low.
- R2: A chain starts only on the rising edge of a qualifying condition. The condition is chan_cfg bit 0 (channel enable) = 1, chan_cfg bit 4 (chain mode) = 1 and link_ptr nonzero. With either bit clear, or with a zero pointer, no read is issued.
- R3: A record is read as REC_WORDS consecutive 32-bit words. The first word is at the pointer address and each following word is 4 bytes higher. A new read is never requested while one is outstanding.
- R4: The record words are used by index. Word 0 loads wk_src, word 1 loads wk_dst, and word 2 bits 16:0 load wk_frag_len while its bit 19 loads wk_last (the final-record flag). Word 3 loads wk_blk, word 4 loads wk_step, and the last word (index REC_WORDS-1) is the next pointer. All other bits of word 2 are ignored.
- R5: xfer_start is high for exactly one cycle. That cycle is the one after the cycle in which the record's last read response arrives.
- R6: rec_done pulses for one cycle, in the cycle after the cycle in which xfer_done is high. If wk_last is 0, the next record is then fetched from the stored next pointer without any change at the inputs.
- R7: When a record with wk_last = 1 completes, chain_done pulses in the same cycle as rec_done. No further read is issued, even though that record's pointer is valid. A new chain needs a fresh rising edge of the R2 condition.
- R8: When chan_cfg bit 0 is cleared, no new read is requested and no start is issued. A read already in flight is allowed to return, and the loader then returns to idle. A later re-enable restarts from link_ptr.
- R9: A read response with mem_err = 1 ends the chain. No further read or start follows, and cfg_err goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_cfg | input | 32 | Channel configuration word (bit 0 enable, bit 4 chain mode) |
| link_ptr | input | AW | Address of the first record's source-address word |
| mem_req | output | 1 | Read request, one cycle per word |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response carries an error |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_done | input | 1 | Transfer engine finished the current record |
| wk_src | output | 32 | Working source address |
| wk_dst | output | 32 | Working destination address |
| wk_frag_len | output | LEN_W | Working fragment length |
| wk_last | output | 1 | Current record is the final one |
| wk_blk | output | 32 | Working block length |
| wk_step | output | 32 | Working transfer step |
| rec_done | output | 1 | One record's transfer completed |
| chain_done | output | 1 | Final record's transfer completed |
| cfg_err | output | 1 | Sticky error from a read response |

## Verification
The next read request follows one cycle after each read response. xfer_start comes exactly one cycle after the final word's response, and rec_done and chain_done come exactly one cycle after xfer_done. The bench keeps a cycle count on the falling edge and records when responses and done pulses arrive. For every start and every completion it checks that the gap is exactly one cycle. Read addresses and the working-register values seen at each start are logged at that same edge and then compared against the ring the bench built in memory. The silence after a final record, after an abort or after an error is checked by watching the request count stay flat for a window of cycles.

// File: rtl/ll_desc_loader.sv
module ll_desc_loader #(
  parameter int AW        = 32,
  parameter int REC_WORDS = 6,
  parameter int LEN_W     = 17,
  parameter int LAST_BIT  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      chan_cfg,
  input  logic [AW-1:0]    link_ptr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err,
  output logic             xfer_start,
  input  logic             xfer_done,
  output logic [31:0]      wk_src,
  output logic [31:0]      wk_dst,
  output logic [LEN_W-1:0] wk_frag_len,
  output logic             wk_last,
  output logic [31:0]      wk_blk,
  output logic [31:0]      wk_step,
  output logic             rec_done,
  output logic             chain_done,
  output logic             cfg_err
);
  localparam int IDX_W    = $clog2(REC_WORDS);
  localparam int LAST_IDX = REC_WORDS - 1;
  localparam int BYTES    = 4;

  typedef enum logic [2:0] {IDLE, FETCH, START, WAIT_DONE, NEXT} state_t;

  state_t          st;
  logic [IDX_W-1:0] idx;
  logic            pend;
  logic            armed_q;
  logic [AW-1:0]   nxt_ptr;

  wire ch_en = chan_cfg[0];
  wire armed = chan_cfg[0] & chan_cfg[4] & (link_ptr != '0);
  wire kick  = armed & ~armed_q;
  wire rsp   = mem_rvalid & pend;
  wire at_end = (idx == IDX_W'(LAST_IDX));

  assign mem_req    = (st == FETCH) & ~pend & ch_en;
  assign xfer_start = (st == START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      idx         <= '0;
      pend        <= 1'b0;
      armed_q     <= 1'b0;
      mem_addr    <= '0;
      nxt_ptr     <= '0;
      wk_src      <= '0;
      wk_dst      <= '0;
      wk_frag_len <= '0;
      wk_last     <= 1'b0;
      wk_blk      <= '0;
      wk_step     <= '0;
      rec_done    <= 1'b0;
      chain_done  <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      armed_q    <= armed;
      rec_done   <= 1'b0;
      chain_done <= 1'b0;
      if (mem_req) pend <= 1'b1;
      else if (rsp) pend <= 1'b0;

      case (st)
        IDLE: begin
          if (kick) begin
            mem_addr <= link_ptr;
            idx      <= '0;
            st       <= FETCH;
          end
        end
        FETCH: begin
          if (rsp) begin
            if (mem_err) begin
              cfg_err <= 1'b1;
              st      <= IDLE;
            end else begin
              if (at_end) begin
                nxt_ptr <= mem_rdata[AW-1:0];
              end else begin
                case (idx)
                  IDX_W'(0): wk_src <= mem_rdata;
                  IDX_W'(1): wk_dst <= mem_rdata;
                  IDX_W'(2): begin
                    wk_frag_len <= mem_rdata[LEN_W-1:0];
                    wk_last     <= mem_rdata[LAST_BIT];
                  end
                  IDX_W'(3): wk_blk  <= mem_rdata;
                  IDX_W'(4): wk_step <= mem_rdata;
                  default: ;
                endcase
              end
              if (!ch_en)      st <= IDLE;
              else if (at_end) st <= START;
              else begin
                idx      <= idx + 1'b1;
                mem_addr <= mem_addr + AW'(BYTES);
              end
            end
          end else if (!ch_en && !pend) begin
            st <= IDLE;
          end
        end
        START: st <= ch_en ? WAIT_DONE : IDLE;
        WAIT_DONE: begin
          if (!ch_en) begin
            st <= IDLE;
          end else if (xfer_done) begin
            rec_done <= 1'b1;
            if (wk_last) begin
              chain_done <= 1'b1;
              st         <= IDLE;
            end else begin
              st <= NEXT;
            end
          end
        end
        NEXT: begin
          mem_addr <= nxt_ptr;
          idx      <= '0;
          st       <= ch_en ? FETCH : IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_desc_loader_chk.sv
module ll_desc_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] chan_cfg,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        mem_err,
  input logic        xfer_start,
  input logic        xfer_done,
  input logic        wk_last,
  input logic        rec_done,
  input logic        chain_done,
  input logic        cfg_err
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          out_q <= 1'b0;
    else if (mem_req)    out_q <= 1'b1;
    else if (mem_rvalid) out_q <= 1'b0;
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!mem_req && !xfer_start && !cfg_err);

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_q);

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_start_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(mem_rvalid));

  assert_rec_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> $past(xfer_done));

  assert_chain_with_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> (rec_done && wk_last));

  assert_no_req_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_cfg[0] |-> !mem_req);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_err && out_q) |=> (!mem_req && !xfer_start));
endmodule

bind ll_desc_loader ll_desc_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_cfg(chan_cfg), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .mem_err(mem_err), .xfer_start(xfer_start),
  .xfer_done(xfer_done), .wk_last(wk_last), .rec_done(rec_done),
  .chain_done(chain_done), .cfg_err(cfg_err)
);

// File: tb/tb_ll_desc_loader.sv
module tb_ll_desc_loader;
  localparam int RW   = 6;
  localparam int HDR  = 2;
  localparam int STR  = HDR + RW;
  localparam int NC   = 4;
  localparam int C_N   [NC] = '{2, 3, 4, 2};
  localparam int C_LAT [NC] = '{0, 2, 1, 4};
  localparam int C_BASE[NC] = '{32'h100, 32'h400, 32'h800, 32'hC00};

  logic clk = 0, rst_n = 0;
  logic [31:0] chan_cfg = 0, link_ptr = 0;
  logic mem_req, mem_rvalid = 0, mem_err = 0, xfer_start, xfer_done = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [31:0] wk_src, wk_dst, wk_blk, wk_step;
  logic [16:0] wk_frag_len;
  logic wk_last, rec_done, chain_done, cfg_err;

  always #5 clk = ~clk;

  ll_desc_loader dut (
    .clk(clk), .rst_n(rst_n), .chan_cfg(chan_cfg), .link_ptr(link_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .wk_src(wk_src), .wk_dst(wk_dst),
    .wk_frag_len(wk_frag_len), .wk_last(wk_last), .wk_blk(wk_blk),
    .wk_step(wk_step), .rec_done(rec_done), .chain_done(chain_done),
    .cfg_err(cfg_err)
  );

  logic [31:0] memw [0:1023];
  int lat = 0, mcnt = 0;
  logic mbusy = 0;
  logic [31:0] raddr = 0, err_addr = 32'hFFFF_FFFF;
  int dcnt = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (mbusy) begin
      if (mcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= memw[raddr[11:2]];
        mem_err    <= (raddr == err_addr);
        mbusy      <= 1'b0;
      end else mcnt <= mcnt - 1;
    end else if (mem_req) begin
      mbusy <= 1'b1;
      mcnt  <= lat;
      raddr <= mem_addr;
    end
    xfer_done <= 1'b0;
    if (dcnt > 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) xfer_done <= 1'b1;
    end else if (xfer_start) dcnt <= 3;
  end

  int cyc = 0, n_req = 0, n_start = 0, n_rec = 0, n_chain = 0, t_err = 0;
  int last_rv = -10, last_dn = -10;
  logic [31:0] alog [64];
  logic [31:0] s_src [8], s_dst [8], s_blk [8], s_step [8], s_len [8];
  logic s_last [8];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req) begin
        if (n_req < 64) alog[n_req] = mem_addr;
        n_req++;
      end
      if (mem_rvalid) last_rv = cyc;
      if (xfer_done) last_dn = cyc;
      if (xfer_start) begin
        if (cyc - last_rv != 1) t_err++;
        if (n_start < 8) begin
          s_src[n_start] = wk_src; s_dst[n_start] = wk_dst;
          s_blk[n_start] = wk_blk; s_step[n_start] = wk_step;
          s_len[n_start] = 32'(wk_frag_len); s_last[n_start] = wk_last;
        end
        n_start++;
      end
      if (rec_done) begin
        if (cyc - last_dn != 1) t_err++;
        n_rec++;
      end
      if (chain_done) n_chain++;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_req = 0; n_start = 0; n_rec = 0; n_chain = 0; t_err = 0;
  endtask

  function automatic logic [31:0] rec_at(int c, int k);
    return 32'(C_BASE[c] + (k * STR + HDR) * 4);
  endfunction
  function automatic logic [31:0] e_len(int c, int k);
    return 32'h1_0000 + 32'(k * 3 + c);
  endfunction

  task automatic build(int c);
    for (int k = 0; k < C_N[c]; k++) begin
      logic [31:0] a;
      a = rec_at(c, k);
      memw[(a >> 2) - 2] = 32'hDEAD_0000;
      memw[(a >> 2) - 1] = 32'hDEAD_0001;
      memw[(a >> 2) + 0] = 32'h1000_0000 + 32'(c << 8) + 32'(k);
      memw[(a >> 2) + 1] = 32'h2000_0000 + 32'(c << 8) + 32'(k);
      memw[(a >> 2) + 2] = e_len(c, k) | 32'h0202_0000 |
                           ((k == C_N[c] - 1) ? 32'h0008_0000 : 32'h0);
      memw[(a >> 2) + 3] = 32'h3000_0000 + 32'(c << 8) + 32'(k);
      memw[(a >> 2) + 4] = 32'h4000_0000 + 32'(c << 8) + 32'(k);
      memw[(a >> 2) + 5] = rec_at(c, (k + 1) % C_N[c]);
    end
  endtask

  task automatic wait_chain(int lim);
    for (int i = 0; i < lim && n_chain == 0; i++) @(posedge clk);
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) memw[i] = 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_req && !xfer_start && !rec_done && !chain_done && !cfg_err,
        "R1", "outputs in reset", {27'b0, mem_req, xfer_start, rec_done, chain_done, cfg_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !cfg_err, "R1", "outputs after reset", {30'b0, mem_req, cfg_err}, 0);

    for (int c = 0; c < NC; c++) begin
      int bad_a, bad_r;
      build(c);
      lat = C_LAT[c];
      clr_logs();
      link_ptr = rec_at(c, 0);
      chan_cfg = 32'h0000_0011;
      wait_chain(2000);
      repeat (40) @(negedge clk);
      chk(n_req == C_N[c] * RW, "R3", "read count", n_req, C_N[c] * RW);
      bad_a = 0;
      for (int k = 0; k < C_N[c]; k++)
        for (int w = 0; w < RW; w++)
          if (alog[k * RW + w] != rec_at(c, k) + 32'(4 * w)) bad_a++;
      chk(bad_a == 0, "R3", "read address order", bad_a, 0);
      chk(n_start == C_N[c], "R6", "records started", n_start, C_N[c]);
      bad_r = 0;
      for (int k = 0; k < C_N[c]; k++) begin
        if (s_src[k]  != 32'h1000_0000 + 32'(c << 8) + 32'(k)) bad_r++;
        if (s_dst[k]  != 32'h2000_0000 + 32'(c << 8) + 32'(k)) bad_r++;
        if (s_blk[k]  != 32'h3000_0000 + 32'(c << 8) + 32'(k)) bad_r++;
        if (s_step[k] != 32'h4000_0000 + 32'(c << 8) + 32'(k)) bad_r++;
        if (s_len[k]  != e_len(c, k)) bad_r++;
        if (s_last[k] != (k == C_N[c] - 1)) bad_r++;
      end
      chk(bad_r == 0, "R4", "working registers at start", bad_r, 0);
      chk(t_err == 0, "R5", "start/done one-cycle timing", t_err, 0);
      chk(n_rec == C_N[c], "R6", "record done pulses", n_rec, C_N[c]);
      chk(n_chain == 1, "R7", "single chain done, no refetch", n_chain, 1);
      chan_cfg = 0;
      repeat (3) @(negedge clk);
    end

    clr_logs();
    chan_cfg = 32'h0000_0001;
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R2", "no reads without chain mode", n_req, 0);
    chan_cfg = 0; link_ptr = 0;
    @(negedge clk);
    chan_cfg = 32'h0000_0011;
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R2", "no reads with zero pointer", n_req, 0);
    chan_cfg = 0;
    @(negedge clk);

    build(1);
    lat = 5;
    clr_logs();
    link_ptr = rec_at(1, 0);
    chan_cfg = 32'h0000_0011;
    for (int i = 0; i < 50 && n_req == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chan_cfg = 0;
    repeat (30) @(negedge clk);
    chk(n_req == 1, "R8", "no new reads after disable", n_req, 1);
    chk(n_start == 0, "R8", "no start after disable", n_start, 0);
    clr_logs();
    chan_cfg = 32'h0000_0011;
    repeat (5) @(negedge clk);
    chk(n_req >= 1 && alog[0] == rec_at(1, 0), "R8", "restart from pointer", alog[0], rec_at(1, 0));
    wait_chain(2000);
    chan_cfg = 0;
    repeat (3) @(negedge clk);

    build(0);
    lat = 1;
    err_addr = rec_at(0, 0) + 8;
    clr_logs();
    link_ptr = rec_at(0, 0);
    chan_cfg = 32'h0000_0011;
    repeat (40) @(negedge clk);
    chk(cfg_err == 1'b1, "R9", "error flag set", cfg_err, 1);
    chk(n_req == 3 && n_start == 0, "R9", "chain halted on error", n_req, 3);
    err_addr = 32'hFFFF_FFFF;
    chan_cfg = 0;
    @(negedge clk);
    clr_logs();
    chan_cfg = 32'h0000_0011;
    wait_chain(2000);
    repeat (5) @(negedge clk);
    chk(n_chain == 1, "R9", "chain runs after error", n_chain, 1);
    chk(cfg_err == 1'b1, "R9", "error flag sticky", cfg_err, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule